// File: doc/BRIEF.md
# SPI Register Access Front End for a Dual-Channel UART Bridge

This block is the host-facing end of a two-channel UART bridge. A host, acting as SPI master, reaches the bridge's register file through it. The block decodes a command byte, then handles the data bytes that follow in one of three ways:

- it passes single register writes and reads out as strobes to the register file;
- it answers level queries on the two FIFOs itself;
- it streams bursts on the holding register into the transmit FIFO of a channel, or out of the receive FIFO of a channel.

The block samples SCLK, chip select and MOSI with the system clock. SCLK must therefore run slowly compared with `clk_i`: each SCLK half period must last at least 4 `clk_i` cycles. Transfers use SPI mode 0, MSB first.

The serialisers are not part of this block. In their place, each channel has a 64-entry transmit FIFO, drained through `tx_pop_i`, and a 64-entry receive FIFO, filled through `rx_push_i`.

Top module: `spi_reg_frontend`

## Requirements
- R1: The command byte is the first byte after chip select falls. Its bits are used as follows:
  - bit 7: 1 selects a read, 0 selects a write;
  - bits 6:3: register address;
  - bit 1: channel;
  - bits 2 and 0: ignored.

  Bits are sampled on SCLK rising edges, MSB first. `miso_o` reads 0 throughout the command byte.
- R2: A write to any address other than 0x0, 0x8 and 0x9 produces exactly one `reg_wr_o` pulse, carrying the address, the channel and the first data byte. Any further bytes in the same transaction produce no strobe.
- R3: A read of any address other than 0x0, 0x8 and 0x9 produces exactly one `reg_rd_o` pulse. The block captures `reg_rdata_i` in the pulse cycle and returns that value in every data byte of the transaction.
- R4: For addresses 0xA to 0xE, `reg_ch_o` is 0 whatever the value of command bit 1.
- R5: A read of address 0x0 with N data bytes returns the next N bytes of the selected channel's receive FIFO, in order, and pops exactly N entries.
- R6: A read of address 0x0 from an empty receive FIFO returns 0x00 and pops nothing.
- R7: A write to address 0x0 with N data bytes pushes all N bytes, in order, into the selected channel's transmit FIFO.
- R8: A byte pushed into a full transmit FIFO is dropped and sets that channel's `tx_ovf_o` bit. The bit stays set until reset, and the other channel's bit is unaffected.
- R9: Address 0x8 reads as FIFO_DEPTH minus the transmit fill count; address 0x9 reads as the receive fill count. Both values are for the selected channel. A write to 0x8 or 0x9 is ignored and a write to 0x0 produces no `reg_wr_o`.
- R10: Raising chip select ends the transaction and discards any partial byte. The next byte after chip select falls again is a command.
- R11: After reset:
  - `miso_o`, both strobes and `tx_ovf_o` are 0;
  - both transmit FIFOs report empty;
  - neither receive FIFO reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from the host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 4 | Address of the current command |
| reg_ch_o | output | 1 | Channel of the current command |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 8 | Register read data, sampled while reg_rd_o is high |
| rx_push_i | input | 2 | Per-channel push into the receive FIFO |
| rx_data_i | input | 16 | Receive push data, channel c in bits 8c+7:8c |
| rx_full_o | output | 2 | Receive FIFO full, per channel |
| tx_pop_i | input | 2 | Per-channel pop from the transmit FIFO |
| tx_data_o | output | 16 | Head of each transmit FIFO, channel c in bits 8c+7:8c |
| tx_empty_o | output | 2 | Transmit FIFO empty, per channel |
| tx_ovf_o | output | 2 | Sticky transmit overflow, per channel |

## Verification
The assertions check, on every cycle, the rules that can be stated at the strobe and flag outputs:

- read and write strobes never coincide;
- each strobe lasts a single cycle;
- a write strobe never carries address 0x0, 0x8 or 0x9;
- the chip-wide addresses always show channel 0;
- an overflow bit, once set, stays set.

The properties that involve the order of data can only be shown by the bench's scenarios. These are:

- FIFO ordering through bursts;
- exact pop counts confirmed through the level register;
- 0x00 returned from an empty receive FIFO;
- drops once the transmit FIFO is full;
- recovery from chip select raised in the middle of a byte.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_HOLD    = 4'h0;
  localparam logic [ADDR_W-1:0] A_TXFREE  = 4'h8;
  localparam logic [ADDR_W-1:0] A_RXLVL   = 4'h9;
  localparam logic [ADDR_W-1:0] A_CHIP_LO = 4'hA;
  localparam logic [ADDR_W-1:0] A_CHIP_HI = 4'hE;

  typedef enum logic {ST_CMD, ST_DATA} xfer_st_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic              ch;
  } cmd_t;

  // address served by the external register file
  function automatic logic is_ext(input logic [ADDR_W-1:0] a);
    return !(a == A_HOLD || a == A_TXFREE || a == A_RXLVL);
  endfunction

  // chip-wide address, channel bit has no meaning
  function automatic logic is_chip(input logic [ADDR_W-1:0] a);
    return (a >= A_CHIP_LO) && (a <= A_CHIP_HI);
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sfe_shifter.sv
// Oversampled SPI mode 0 bit engine: sample on SCLK rise, shift out on fall.
module sfe_shifter #(
  parameter int unsigned  W     = 8,
  localparam int unsigned CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         cs_ni,
  input  logic         mosi_i,
  input  logic [W-1:0] load_byte_i,
  output logic         sel_o,
  output logic         byte_start_o,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o,
  output logic         load_o,
  output logic         miso_o
);
  logic             sclk_s, cs_n_s, mosi_s, sclk_d;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt_q;
  logic [W-2:0]     sh_in_q;
  logic [W-1:0]     sh_out_q;

  sfe_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    ({sclk_s, cs_n_s, mosi_s})
  );

  assign sel_o = !cs_n_s;
  assign rise  = sel_o && sclk_s && !sclk_d;
  assign fall  = sel_o && !sclk_s && sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      cnt_q    <= '0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (!sel_o) begin
        cnt_q    <= '0;
        sh_out_q <= '0;
      end else begin
        if (rise) begin
          cnt_q   <= (cnt_q == CNT_W'(W - 1)) ? '0 : cnt_q + 1'b1;
          sh_in_q <= {sh_in_q[W-3:0], mosi_s};
        end
        if (fall) begin
          if (cnt_q == '0) sh_out_q <= load_byte_i;
          else             sh_out_q <= {sh_out_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign byte_start_o = rise && (cnt_q == '0);
  assign byte_done_o  = rise && (cnt_q == CNT_W'(W - 1));
  assign byte_o       = {sh_in_q, mosi_s};
  assign load_o       = fall && (cnt_q == '0);
  assign miso_o       = sh_out_q[W-1];
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend import sfe_pkg::*; #(
  parameter int unsigned  FIFO_DEPTH = 64,
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     cs_ni,
  input  logic                     mosi_i,
  output logic                     miso_o,
  output logic                     reg_wr_o,
  output logic                     reg_rd_o,
  output logic [ADDR_W-1:0]        reg_addr_o,
  output logic                     reg_ch_o,
  output logic [BYTE_W-1:0]        reg_wdata_o,
  input  logic [BYTE_W-1:0]        reg_rdata_i,
  input  logic [NUM_CH-1:0]        rx_push_i,
  input  logic [NUM_CH*BYTE_W-1:0] rx_data_i,
  output logic [NUM_CH-1:0]        rx_full_o,
  input  logic [NUM_CH-1:0]        tx_pop_i,
  output logic [NUM_CH*BYTE_W-1:0] tx_data_o,
  output logic [NUM_CH-1:0]        tx_empty_o,
  output logic [NUM_CH-1:0]        tx_ovf_o
);
  logic              sel, byte_start, byte_done, load_evt;
  logic [BYTE_W-1:0] byte_val, load_byte;

  xfer_st_e          state_q;
  cmd_t              cmd_q, cmd_d;
  logic              cmd_fresh_q, first_data_q, loaded_valid_q, wr_q;
  logic [BYTE_W-1:0] rd_hold_q, wdata_q;
  logic [NUM_CH-1:0] ovf_q, ovf_set;

  logic [NUM_CH-1:0] tx_push, tx_full, rx_pop, rx_empty;
  logic [CNT_W-1:0]  tx_cnt [NUM_CH];
  logic [CNT_W-1:0]  rx_cnt [NUM_CH];
  logic [BYTE_W-1:0] rx_head [NUM_CH];

  logic              in_data, rhr_rd, data_wr_byte;

  sfe_shifter #(.W(BYTE_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .cs_ni        (cs_ni),
    .mosi_i       (mosi_i),
    .load_byte_i  (load_byte),
    .sel_o        (sel),
    .byte_start_o (byte_start),
    .byte_done_o  (byte_done),
    .byte_o       (byte_val),
    .load_o       (load_evt),
    .miso_o       (miso_o)
  );

  // command decode
  always_comb begin
    cmd_d.rd   = byte_val[7];
    cmd_d.addr = byte_val[6:3];
    cmd_d.ch   = is_chip(byte_val[6:3]) ? 1'b0 : byte_val[1];
  end

  assign in_data      = (state_q == ST_DATA);
  assign rhr_rd       = in_data && cmd_q.rd && (cmd_q.addr == A_HOLD);
  assign data_wr_byte = byte_done && in_data && !cmd_q.rd;

  // byte presented at the next byte boundary
  always_comb begin
    load_byte = '0;
    if (in_data && cmd_q.rd) begin
      if (cmd_q.addr == A_HOLD) load_byte = rx_empty[cmd_q.ch] ? '0 : rx_head[cmd_q.ch];
      else                      load_byte = rd_hold_q;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic CH = 1'(g);

    assign tx_push[g] = data_wr_byte && (cmd_q.addr == A_HOLD) && (cmd_q.ch == CH);
    assign rx_pop[g]  = byte_start && rhr_rd && loaded_valid_q && (cmd_q.ch == CH);
    assign ovf_set[g] = tx_push[g] && tx_full[g];

    sfe_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (tx_push[g]),
      .wdata_i (byte_val),
      .pop_i   (tx_pop_i[g]),
      .rdata_o (tx_data_o[g*BYTE_W +: BYTE_W]),
      .empty_o (tx_empty_o[g]),
      .full_o  (tx_full[g]),
      .count_o (tx_cnt[g])
    );

    sfe_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (rx_push_i[g]),
      .wdata_i (rx_data_i[g*BYTE_W +: BYTE_W]),
      .pop_i   (rx_pop[g]),
      .rdata_o (rx_head[g]),
      .empty_o (rx_empty[g]),
      .full_o  (rx_full_o[g]),
      .count_o (rx_cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= ovf_q | ovf_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_CMD;
      cmd_q          <= '0;
      cmd_fresh_q    <= 1'b0;
      first_data_q   <= 1'b0;
      loaded_valid_q <= 1'b0;
      wr_q           <= 1'b0;
      wdata_q        <= '0;
      rd_hold_q      <= '0;
    end else if (!sel) begin
      state_q        <= ST_CMD;
      cmd_fresh_q    <= 1'b0;
      first_data_q   <= 1'b0;
      loaded_valid_q <= 1'b0;
      wr_q           <= 1'b0;
    end else begin
      cmd_fresh_q <= 1'b0;
      wr_q        <= 1'b0;
      if (byte_done) begin
        if (!in_data) begin
          cmd_q        <= cmd_d;
          state_q      <= ST_DATA;
          cmd_fresh_q  <= 1'b1;
          first_data_q <= 1'b1;
        end else begin
          first_data_q <= 1'b0;
          if (!cmd_q.rd && first_data_q && is_ext(cmd_q.addr)) begin
            wr_q    <= 1'b1;
            wdata_q <= byte_val;
          end
        end
      end
      // read value is frozen once per transaction
      if (cmd_fresh_q) begin
        case (cmd_q.addr)
          A_TXFREE: rd_hold_q <= BYTE_W'(CNT_W'(FIFO_DEPTH) - tx_cnt[cmd_q.ch]);
          A_RXLVL:  rd_hold_q <= BYTE_W'(rx_cnt[cmd_q.ch]);
          default:  rd_hold_q <= reg_rdata_i;
        endcase
      end
      if (load_evt) loaded_valid_q <= rhr_rd && !rx_empty[cmd_q.ch];
    end
  end

  assign reg_rd_o    = cmd_fresh_q && cmd_q.rd && is_ext(cmd_q.addr);
  assign reg_wr_o    = wr_q;
  assign reg_addr_o  = cmd_q.addr;
  assign reg_ch_o    = cmd_q.ch;
  assign reg_wdata_o = wdata_q;
  assign tx_ovf_o    = ovf_q;
endmodule

// File: rtl/spi_reg_frontend_chk.sv
module spi_reg_frontend_chk import sfe_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_ch_o,
  input logic [NUM_CH-1:0] tx_ovf_o
);
  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));

  a_r2_wr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r3_rd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r9_wr_not_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_addr_o != 4'h0 && reg_addr_o != 4'h8 && reg_addr_o != 4'h9));

  a_r4_chip_reg_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_wr_o || reg_rd_o) && reg_addr_o >= 4'hA && reg_addr_o <= 4'hE) |-> !reg_ch_o);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ovf
    a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ovf_o[g] |=> tx_ovf_o[g]);
  end
endmodule

bind spi_reg_frontend spi_reg_frontend_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_addr_o (reg_addr_o),
  .reg_ch_o   (reg_ch_o),
  .tx_ovf_o   (tx_ovf_o)
);

// File: tb/spi_reg_frontend_tb.sv
module spi_reg_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic        reg_wr, reg_rd, reg_ch;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [1:0]  rx_push = '0, rx_full, tx_pop = '0, tx_empty, tx_ovf;
  logic [15:0] rx_data = '0, tx_data;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [3:0] wr_addr, rd_addr;
  logic       wr_ch, rd_ch;
  logic [7:0] wr_data;
  logic [7:0] rbuf [0:127];
  logic [7:0] wbuf [0:127];
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] host_val(input logic [3:0] a, input logic c);
    return {a, 3'b011, c} ^ 8'h96;
  endfunction

  function automatic logic [7:0] mk_cmd(input logic rd, input logic [3:0] a,
                                        input logic c, input logic [1:0] junk);
    return {rd, a, junk[1], c, junk[0]};
  endfunction

  function automatic logic exp_ch(input logic [3:0] a, input logic c);
    return (a >= 4'hA && a <= 4'hE) ? 1'b0 : c;
  endfunction

  assign reg_rdata = host_val(reg_addr, reg_ch);

  spi_reg_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr), .reg_ch_o(reg_ch),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_full_o(rx_full),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_empty_o(tx_empty), .tx_ovf_o(tx_ovf)
  );

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; wr_addr = reg_addr; wr_ch = reg_ch; wr_data = reg_wdata; end
    if (reg_rd) begin rd_cnt++; rd_addr = reg_addr; rd_ch = reg_ch; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b >= 8 - nb; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk); cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  // command, then n bytes; received bytes land in rbuf, sent from wbuf
  task automatic xact(input logic [7:0] cmd, input int n, input bit rd);
    logic [7:0] r;
    cs_on();
    xfer_bits(cmd, 8, r);
    chk("R1 miso during command", r, 8'h00);
    for (int k = 0; k < n; k++) begin
      xfer_bits(rd ? 8'h00 : wbuf[k], 8, r);
      rbuf[k] = r;
    end
    cs_off();
  endtask

  task automatic rd_level(input logic [3:0] a, input logic c, output logic [7:0] v);
    xact(mk_cmd(1'b1, a, c, 2'b00), 1, 1'b1);
    v = rbuf[0];
  endtask

  task automatic push_rx(input int c, input logic [7:0] d);
    @(negedge clk); rx_data[c*8 +: 8] = d; rx_push[c] = 1'b1;
    @(negedge clk); rx_push[c] = 1'b0;
  endtask

  task automatic pop_tx(input int c, output logic [7:0] d);
    @(negedge clk); d = tx_data[c*8 +: 8]; tx_pop[c] = 1'b1;
    @(negedge clk); tx_pop[c] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] v, d;
    logic [7:0] rxm [0:7];
    int wc, rc;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 miso", miso, 0);
    chk("R11 tx_empty", tx_empty, 2'b11);
    chk("R11 tx_ovf", tx_ovf, 2'b00);
    chk("R11 rx_full", rx_full, 2'b00);
    chk("R11 strobes", {reg_wr, reg_rd}, 2'b00);

    // R1 R2: write reg 3 ch1 with junk bits set, plus trailing byte
    wc = wr_cnt;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    xact(mk_cmd(1'b0, 4'h3, 1'b1, 2'b11), 2, 1'b0);
    chk("R2 one write strobe", wr_cnt - wc, 1);
    chk("R1 write addr", wr_addr, 4'h3);
    chk("R1 write ch", wr_ch, 1'b1);
    chk("R2 write data", wr_data, 8'hA5);

    // R3: read reg 5 ch0, three bytes
    rc = rd_cnt;
    xact(mk_cmd(1'b1, 4'h5, 1'b0, 2'b01), 3, 1'b1);
    chk("R3 one read strobe", rd_cnt - rc, 1);
    for (int k = 0; k < 3; k++) chk("R3 repeated value", rbuf[k], host_val(4'h5, 1'b0));

    // R4: chip-wide registers ignore channel bit
    wbuf[0] = 8'h42;
    xact(mk_cmd(1'b0, 4'hC, 1'b1, 2'b00), 1, 1'b0);
    chk("R4 write ch forced 0", wr_ch, 1'b0);
    xact(mk_cmd(1'b1, 4'hB, 1'b1, 2'b00), 1, 1'b1);
    chk("R4 read ch forced 0", rd_ch, 1'b0);
    chk("R4 read data", rbuf[0], host_val(4'hB, 1'b0));

    // R1 R2 R3: random register traffic
    for (int it = 0; it < 16; it++) begin
      int r, n;
      logic [3:0] a;
      logic c, rdb;
      logic [1:0] j;
      r = $urandom_range(0, 12);
      a = (r < 7) ? 4'(r + 1) : 4'(r + 3);
      c = 1'($urandom); rdb = 1'($urandom); j = 2'($urandom);
      n = $urandom_range(1, 3);
      wc = wr_cnt; rc = rd_cnt;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      xact(mk_cmd(rdb, a, c, j), n, rdb);
      if (rdb) begin
        chk("R3 rand read strobe", rd_cnt - rc, 1);
        chk("R1 rand read addr", rd_addr, a);
        chk("R4 rand read ch", rd_ch, exp_ch(a, c));
        for (int k = 0; k < n; k++) chk("R3 rand read data", rbuf[k], host_val(a, exp_ch(a, c)));
      end else begin
        chk("R2 rand write strobe", wr_cnt - wc, 1);
        chk("R1 rand write addr", wr_addr, a);
        chk("R4 rand write ch", wr_ch, exp_ch(a, c));
        chk("R2 rand write data", wr_data, wbuf[0]);
      end
    end

    // R5 R6 R9: receive FIFO bursts on ch1
    for (int k = 0; k < 5; k++) begin
      rxm[k] = 8'($urandom);
      push_rx(1, rxm[k]);
    end
    rd_level(4'h9, 1'b1, v); chk("R9 rx level ch1", v, 8'd5);
    rd_level(4'h9, 1'b0, v); chk("R9 rx level ch0", v, 8'd0);
    rc = rd_cnt;
    xact(mk_cmd(1'b1, 4'h0, 1'b1, 2'b00), 3, 1'b1);
    for (int k = 0; k < 3; k++) chk("R5 rx burst data", rbuf[k], rxm[k]);
    chk("R5 no read strobe on holding reg", rd_cnt - rc, 0);
    rd_level(4'h9, 1'b1, v); chk("R5 exactly N popped", v, 8'd2);
    xact(mk_cmd(1'b1, 4'h0, 1'b1, 2'b00), 4, 1'b1);
    chk("R5 remaining 0", rbuf[0], rxm[3]);
    chk("R5 remaining 1", rbuf[1], rxm[4]);
    chk("R6 empty read 0", rbuf[2], 8'h00);
    chk("R6 empty read 1", rbuf[3], 8'h00);
    rd_level(4'h9, 1'b1, v); chk("R6 level stays 0", v, 8'd0);

    // R7 R9: transmit burst on ch0
    wc = wr_cnt;
    for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
    xact(mk_cmd(1'b0, 4'h0, 1'b0, 2'b10), 4, 1'b0);
    chk("R9 no write strobe for holding reg", wr_cnt - wc, 0);
    rd_level(4'h8, 1'b0, v); chk("R9 tx free ch0", v, 8'(DEPTH - 4));
    rd_level(4'h8, 1'b1, v); chk("R9 tx free ch1", v, 8'(DEPTH));
    for (int k = 0; k < 4; k++) begin
      pop_tx(0, d);
      chk("R7 tx order", d, wbuf[k]);
    end
    chk("R7 tx drained", tx_empty[0], 1'b1);

    // R9: writes to level registers ignored
    wc = wr_cnt;
    wbuf[0] = 8'h12;
    xact(mk_cmd(1'b0, 4'h8, 1'b0, 2'b00), 1, 1'b0);
    chk("R9 level write no strobe", wr_cnt - wc, 0);
    rd_level(4'h8, 1'b0, v); chk("R9 level unchanged", v, 8'(DEPTH));

    // R8: overflow on ch1
    for (int k = 0; k < DEPTH + 2; k++) wbuf[k] = 8'($urandom);
    xact(mk_cmd(1'b0, 4'h0, 1'b1, 2'b00), DEPTH + 2, 1'b0);
    chk("R8 ovf flag", tx_ovf, 2'b10);
    rd_level(4'h8, 1'b1, v); chk("R8 tx free at full", v, 8'd0);
    for (int k = 0; k < DEPTH; k++) begin
      pop_tx(1, d);
      chk("R8 stored bytes", d, wbuf[k]);
    end
    chk("R8 extra dropped", tx_empty[1], 1'b1);
    chk("R8 ovf sticky", tx_ovf, 2'b10);

    // R10: abort during command byte
    cs_on(); xfer_bits(8'h1F, 4, v); cs_off();
    wc = wr_cnt;
    wbuf[0] = 8'h77;
    xact(mk_cmd(1'b0, 4'h2, 1'b0, 2'b00), 1, 1'b0);
    chk("R10 recovery strobe", wr_cnt - wc, 1);
    chk("R10 recovery addr", wr_addr, 4'h2);
    chk("R10 recovery data", wr_data, 8'h77);
    // R10: abort during data byte
    wc = wr_cnt;
    cs_on(); xfer_bits(mk_cmd(1'b0, 4'h6, 1'b0, 2'b00), 8, v); xfer_bits(8'hE1, 5, v); cs_off();
    chk("R10 partial data no strobe", wr_cnt - wc, 0);

    report();
  end
endmodule